// File: doc/BRIEF.md
# Fan Tachometer Capture Timer

This block measures fan speed from two tachometer pulse trains. Each of its two channels owns a down-counter that runs on a divided copy of the bus clock. The counter starts at all ones, and a falling edge on the channel's tach input latches its current count into a capture register. Software recovers the pulse period as the reload value minus the latched count. The block also watches for fans that are too slow. When a running counter steps down onto a programmed compare value, the channel raises a timeout flag. The fixed distance between the reload and the default compare value sets the slowest pulse rate that can still be measured.

Capture and timeout events set pending flags, and software clears them by writing ones. Clearing a channel's capture flag also reloads that channel's counter, so the next period starts from the top. A single interrupt line combines the pending flags with a per-flag enable mask. Both counters share one prescaler. Each counter has its own clock-gate bit, so an idle channel stays frozen.

Register map on the shared `addr` (all reads are combinational):

| addr | Register |
|------|----------|
| 0 | Counter A |
| 1 | Counter B |
| 2 | Capture A (read only) |
| 3 | Capture B (read only) |
| 4 | Prescale |
| 5 | Clock gate |
| 6 | Capture mode |
| 7 | Pending (read only) |
| 8 | Clear |
| 9 | Interrupt enable |
| 10 | Compare enable |
| 11 | Compare A |
| 12 | Compare B |

Top module: `fan_tach_timer`

## Requirements
- R1: After reset the following hold. Both counters read 0xFFFF. Prescale reads 255. Both compare values read 0xAFFF (0xFFFF minus 0x5000). Pending, interrupt enable, clock gate, mode and compare enable read 0. `irq` is low.
- R2: While its clock gate is set, a counter decrements once every prescale+1 bus clocks. Two captures taken 40 clocks apart therefore differ by 40 when prescale is 0, and by 10 when prescale is 3.
- R3: The clock-gate register (addr 5) enables counter A with bit 0 and counter B with bit 3. A counter whose gate bit is clear holds its value.
- R4: A capture loads the counter value into the capture register and sets pending bit 0 (channel A) or bit 1 (channel B). It occurs on a high-to-low transition of the synchronized tach input, but only when the channel's gate bit is set, mode bit 2 is set, and the channel enable bit is set (bit 5 for A, bit 6 for B). Rising edges never capture.
- R5: A falling edge that arrives while the channel's mode enable bits are not set leaves the pending flags and the capture register unchanged.
- R6: With compare-enable bit 2 (A) or bit 6 (B) set at addr 10, a counter that decrements onto its compare value sets pending bit 4 (A) or bit 5 (B). With the enable bit clear, no timeout flag is set.
- R7: A write to the clear register (addr 8) clears every pending bit in 5:0 that is written as one and leaves the others unchanged. Clear bit 0 reloads counter A to 0xFFFF, and clear bit 1 reloads counter B. Clearing a timeout bit does not reload a counter.
- R8: `irq` is high exactly when some pending bit and its interrupt-enable bit (addr 9, same positions) are both set.
- R9: Unimplemented bits read as zero. The implemented bits are: enable mask 0x33, compare enable 0x44, mode 0x64, clock gate 0x09, prescale 0x00FF. Capture registers ignore writes, and pending bits 3:2 are always zero.
- R10: A counter that reaches zero stays at zero until software writes it or clears its capture flag.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register write strobe |
| addr | input | 4 | Register address for write and read |
| wr_data | input | 16 | Write data |
| rd_data | output | 16 | Read data for `addr` |
| tach_a | input | 1 | Tach input, channel A (asynchronous) |
| tach_b | input | 1 | Tach input, channel B (asynchronous) |
| irq | output | 1 | Combined interrupt |

## Verification
A bad prescaler phase or a wrongly gated counter shows up directly as a wrong difference between two captures of the same channel, visible as soon as the second capture lands three clocks after its edge. A missing reload or a missing hold at zero appears on the counter read-back in the cycle after the clear write, or after the counter has stopped. A flag set or cleared at the wrong position is seen on the pending register and on `irq` within one clock of the event.

// File: rtl/fan_tach_timer.sv
`timescale 1ns/1ps
module fan_tach_timer #(
  parameter int CNT_W    = 16,
  parameter int PS_W     = 8,
  parameter int PS_RESET = 255,
  parameter int WINDOW   = 'h5000,
  parameter int SYNC     = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [3:0]       addr,
  input  logic [CNT_W-1:0] wr_data,
  output logic [CNT_W-1:0] rd_data,
  input  logic             tach_a,
  input  logic             tach_b,
  output logic             irq
);
  localparam logic [CNT_W-1:0] RELOAD    = '1;
  localparam logic [CNT_W-1:0] CMP_RESET = RELOAD - CNT_W'(WINDOW);
  localparam int GATE_BIT [2] = '{0, 3};
  localparam int EN_BIT   [2] = '{5, 6};
  localparam int CMP_BIT  [2] = '{2, 6};
  localparam logic [3:0] A_PS = 4'd4, A_GATE = 4'd5, A_MODE = 4'd6, A_PEND = 4'd7,
                         A_CLR = 4'd8, A_IEN = 4'd9, A_CMPEN = 4'd10;

  logic [PS_W-1:0]  ps_val, ps_cnt;
  logic [7:0]       gate_r, mode_r, cmpen_r;
  logic [5:0]       ien_r, pend;
  logic [CNT_W-1:0] cnt [2];
  logic [CNT_W-1:0] cap [2];
  logic [CNT_W-1:0] cmp [2];
  logic [1:0]       cap_hit, to_hit;
  logic             tick;
  logic             clr_wr;

  assign tick   = ps_cnt >= ps_val;
  assign clr_wr = wr_en && addr == A_CLR;

  always_ff @(posedge clk) begin
    if (!rst_n) ps_cnt <= '0;
    else if (!(gate_r[0] || gate_r[3]) || tick) ps_cnt <= '0;
    else ps_cnt <= ps_cnt + 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ps_val  <= PS_W'(PS_RESET);
      gate_r  <= '0;
      mode_r  <= '0;
      cmpen_r <= '0;
      ien_r   <= '0;
    end else if (wr_en) begin
      case (addr)
        A_PS:    ps_val  <= wr_data[PS_W-1:0];
        A_GATE:  gate_r  <= wr_data[7:0] & 8'h09;
        A_MODE:  mode_r  <= wr_data[7:0] & 8'h64;
        A_CMPEN: cmpen_r <= wr_data[7:0] & 8'h44;
        A_IEN:   ien_r   <= wr_data[5:0] & 6'h33;
        default: ;
      endcase
    end
  end

  for (genvar c = 0; c < 2; c++) begin : g_ch
    logic [SYNC:0]    sy;
    logic             fall, run, dec, wr_cnt, reload;
    logic [CNT_W-1:0] nxt;

    always_ff @(posedge clk) begin
      if (!rst_n) sy <= '1;
      else sy <= {sy[SYNC-1:0], (c == 0) ? tach_a : tach_b};
    end

    assign fall   = sy[SYNC] & ~sy[SYNC-1];
    assign run    = gate_r[GATE_BIT[c]];
    assign dec    = run && tick && cnt[c] != '0;
    assign nxt    = cnt[c] - 1'b1;
    assign wr_cnt = wr_en && addr == 4'(c);
    assign reload = clr_wr && wr_data[c];

    assign cap_hit[c] = run && mode_r[2] && mode_r[EN_BIT[c]] && fall;
    assign to_hit[c]  = dec && cmpen_r[CMP_BIT[c]] && nxt == cmp[c];

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        cnt[c] <= RELOAD;
        cap[c] <= '0;
        cmp[c] <= CMP_RESET;
      end else begin
        if (wr_cnt)      cnt[c] <= wr_data;
        else if (reload) cnt[c] <= RELOAD;
        else if (dec)    cnt[c] <= nxt;
        if (cap_hit[c])  cap[c] <= cnt[c];
        if (wr_en && addr == 4'(11 + c)) cmp[c] <= wr_data;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) pend <= '0;
    else pend <= (pend & ~(clr_wr ? wr_data[5:0] : 6'd0))
               | {to_hit, 2'b00, cap_hit};
  end

  assign irq = |(pend & ien_r);

  always_comb begin
    case (addr)
      4'd0:    rd_data = cnt[0];
      4'd1:    rd_data = cnt[1];
      4'd2:    rd_data = cap[0];
      4'd3:    rd_data = cap[1];
      A_PS:    rd_data = CNT_W'(ps_val);
      A_GATE:  rd_data = CNT_W'(gate_r);
      A_MODE:  rd_data = CNT_W'(mode_r);
      A_PEND:  rd_data = CNT_W'(pend);
      A_IEN:   rd_data = CNT_W'(ien_r);
      A_CMPEN: rd_data = CNT_W'(cmpen_r);
      4'd11:   rd_data = cmp[0];
      4'd12:   rd_data = cmp[1];
      default: rd_data = '0;
    endcase
  end
endmodule

module fan_tach_timer_chk #(parameter int CNT_W = 16) (
  input logic             clk,
  input logic             rst_n,
  input logic             irq,
  input logic [5:0]       pend,
  input logic [5:0]       ien_r,
  input logic             run0,
  input logic             cap_ok,
  input logic             wr0,
  input logic             clr0,
  input logic [CNT_W-1:0] cnt0
);
  assert_irq_stable_R8: assert property (@(posedge clk) disable iff (!rst_n)
    ($stable(pend) && $stable(ien_r)) |-> $stable(irq));
  assert_reload_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (clr0 && !wr0) |=> cnt0 == '1);
  assert_gate_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (!run0 && !wr0 && !clr0) |=> $stable(cnt0));
  assert_single_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (run0 && !wr0 && !clr0) |=> (cnt0 == $past(cnt0) || cnt0 == CNT_W'($past(cnt0) - 1'b1)));
  assert_capture_gated_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(pend[0]) |-> $past(cap_ok));
  assert_pend_gap_R9: assert property (@(posedge clk) disable iff (!rst_n)
    pend[3:2] == 2'b00);
  assert_zero_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt0 == '0 && !wr0 && !clr0) |=> cnt0 == '0);
endmodule

bind fan_tach_timer fan_tach_timer_chk #(.CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .irq(irq), .pend(pend), .ien_r(ien_r),
  .run0(gate_r[0]), .cap_ok(gate_r[0] & mode_r[2] & mode_r[5]),
  .wr0(wr_en && addr == 4'd0), .clr0(wr_en && addr == 4'd8 && wr_data[0]),
  .cnt0(cnt[0])
);

// File: tb/fan_tach_timer_test.sv
`timescale 1ns/1ps
module fan_tach_timer_test;
  logic clk = 0, rst_n = 0, wr_en = 0, tach_a = 1, tach_b = 1;
  logic [3:0]  addr = 0;
  logic [15:0] wr_data = 0;
  wire  [15:0] rd_data;
  wire         irq;
  int checks = 0, fails = 0;
  bit done = 0;

  fan_tach_timer uut (.clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr),
    .wr_data(wr_data), .rd_data(rd_data), .tach_a(tach_a), .tach_b(tach_b), .irq(irq));

  always #4 clk = ~clk;

  // {addr, write data, expected read-back} -- R9
  localparam logic [35:0] VEC [10] = '{
    {4'd9,  16'hFFFF, 16'h0033}, {4'd10, 16'hFFFF, 16'h0044},
    {4'd6,  16'hFFFF, 16'h0064}, {4'd4,  16'hFFFF, 16'h00FF},
    {4'd12, 16'h1357, 16'h1357}, {4'd5,  16'hFFFF, 16'h0009},
    {4'd5,  16'h0000, 16'h0000}, {4'd2,  16'hFFFF, 16'h0000},
    {4'd9,  16'h0000, 16'h0000}, {4'd10, 16'h0000, 16'h0000}};

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [15:0] d);
    @(negedge clk); wr_en = 1; addr = a; wr_data = d;
    @(negedge clk); wr_en = 0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [15:0] d);
    addr = a; #1; d = rd_data;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic cap_run(input logic [15:0] ps, input logic [15:0] exp_diff);
    logic [15:0] c1, c2, p;
    wr(4'd5, 16'h0); wr(4'd8, 16'h3F); wr(4'd4, ps);
    wr(4'd6, 16'h64); wr(4'd5, 16'h1);
    @(negedge clk); tach_a = 0;
    idle(10); rd(4'd2, c1); rd(4'd7, p);
    chk("R4 capture A sets pending bit 0", p, 16'h0001);
    tach_a = 1;
    idle(30); tach_a = 0;
    idle(10); rd(4'd2, c2);
    chk("R2 capture spacing vs prescale", c1 - c2, exp_diff);
    tach_a = 1; idle(5);
  endtask

  initial begin
    #(8 * 200000);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [15:0] v, v2;
    idle(3); rst_n = 1; idle(1);
    rd(4'd0, v);  chk("R1 counter A reset", v, 16'hFFFF);
    rd(4'd4, v);  chk("R1 prescale reset", v, 16'h00FF);
    rd(4'd11, v); chk("R1 compare A reset", v, 16'hAFFF);
    rd(4'd7, v);  chk("R1 pending reset", v, 16'h0);
    rd(4'd9, v);  chk("R1 enable reset", v, 16'h0);
    chk("R1 irq reset", {15'd0, irq}, 16'h0);

    for (int i = 0; i < 10; i++) begin
      wr(VEC[i][35:32], VEC[i][31:16]);
      rd(VEC[i][35:32], v);
      chk("R9 register read-back mask", v, VEC[i][15:0]);
    end

    cap_run(16'd0, 16'd40);
    cap_run(16'd3, 16'd10);

    // R5: falling edge with mode disabled is ignored; R4: rising edge ignored
    wr(4'd8, 16'h3F); rd(4'd2, v2);
    wr(4'd6, 16'h00);
    @(negedge clk); tach_a = 0; idle(8);
    rd(4'd7, v); chk("R5 disabled edge leaves pending", v, 16'h0);
    rd(4'd2, v); chk("R5 disabled edge leaves capture", v, v2);
    wr(4'd6, 16'h64);
    @(negedge clk); tach_a = 1; idle(8);
    rd(4'd7, v); chk("R4 rising edge does not capture", v, 16'h0);

    // channel B capture
    wr(4'd5, 16'h08); wr(4'd6, 16'h44);
    @(negedge clk); tach_b = 0; idle(8);
    rd(4'd7, v); chk("R4 capture B sets pending bit 1", v, 16'h0002);
    tach_b = 1; idle(4);

    // R3 gating
    wr(4'd5, 16'h0); wr(4'd8, 16'h3F);
    wr(4'd0, 16'h1234); wr(4'd1, 16'h1234); wr(4'd4, 16'h0);
    wr(4'd5, 16'h08); idle(10);
    rd(4'd0, v); chk("R3 gate bit 0 clear holds A", v, 16'h1234);
    wr(4'd5, 16'h0);
    rd(4'd1, v2); chk("R3 gate bit 3 runs B", {15'd0, v2 < 16'h1234}, 16'h1);
    idle(10);
    rd(4'd1, v); chk("R3 stopped B holds", v, v2);

    // R6 timeout disabled
    wr(4'd0, 16'hB004); wr(4'd10, 16'h00); wr(4'd5, 16'h01); idle(20);
    wr(4'd5, 16'h0);
    rd(4'd7, v); chk("R6 no timeout with compare disabled", v, 16'h0);

    // R6 timeout enabled, R8 interrupt
    wr(4'd0, 16'hB004); wr(4'd10, 16'h04); wr(4'd9, 16'h10);
    chk("R8 irq low before event", {15'd0, irq}, 16'h0);
    wr(4'd5, 16'h01); idle(20); wr(4'd5, 16'h0);
    rd(4'd7, v); chk("R6 timeout A sets pending bit 4", v, 16'h0010);
    chk("R8 irq with enabled flag", {15'd0, irq}, 16'h1);
    wr(4'd9, 16'h01);
    chk("R8 irq masked", {15'd0, irq}, 16'h0);
    rd(4'd0, v2);
    wr(4'd8, 16'h10);
    rd(4'd7, v); chk("R7 clear timeout bit", v, 16'h0);
    rd(4'd0, v); chk("R7 timeout clear does not reload", v, v2);

    // R10 hold at zero, R7 reload
    wr(4'd10, 16'h0); wr(4'd0, 16'h0003); wr(4'd5, 16'h01); idle(20);
    rd(4'd0, v); chk("R10 counter stops at zero", v, 16'h0);
    wr(4'd5, 16'h0); wr(4'd8, 16'h01);
    rd(4'd0, v); chk("R7 capture clear reloads A", v, 16'hFFFF);

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule